// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a small 32-bit processor. In every clock cycle it reads one instruction, decodes it and carries it out. It handles five register-to-register operations (add, subtract, and, or, signed set-less-than), word load, word store, branch-if-equal and an unconditional jump. The block holds the program counter, a 32-entry register file, a sign extender, an ALU and a two-level decoder. In the first level the opcode picks an ALU class. In the second level that class, with the function field where it applies, picks the ALU operation.

The instruction store and the data store are word-addressed arrays inside the block. A host fills them through a preload port while it holds reset low. Once reset is released, the core runs from address 0. A debug port reads any register or any data word combinationally, so that the host can see the results.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, the next rising edge sets the PC to 0 and clears every register. The preload port works during reset, and reset does not touch either memory.
- R2: With `ld_en` high, a rising edge writes `ld_data` into word `ld_addr`. The word goes to the data store when `ld_dmem`=1 and to the instruction store when `ld_dmem`=0.
- R3: Fields are opcode[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0] and imm[15:0]. Opcode 000000 is register-to-register and writes rd with rs op rt. funct 100000 selects add, 100010 selects subtract, 100100 selects and, 100101 selects or.
- R4: funct 101010 writes 1 to rd when rs is less than rt as signed 32-bit numbers, and 0 otherwise.
- R5: Opcode 100011 loads the data word at byte address rs + sign-extended imm into rt. Opcode 101011 stores rt to that address. The word index is address[..:2], and negative offsets are supported.
- R6: Opcode 000100 compares rs with rt by subtraction. When they are equal, the PC becomes PC+4 + (sign-extended imm << 2). Otherwise the PC becomes PC+4.
- R7: Opcode 000010 sets the PC to {PC+4[31:28], instr[25:0], 2'b00}.
- R8: Register 0 always reads as 0, and writes to it are dropped.
- R9: An unknown opcode, or an unknown funct under opcode 000000, writes neither a register nor memory, and the PC advances by 4.
- R10: Every instruction other than a taken branch or a jump advances the PC by 4 in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 1 for the data store, 0 for the instruction store |
| ld_addr | input | LAW | Preload word index |
| ld_data | input | 32 | Preload word |
| dbg_reg_sel | input | 5 | Register index for the debug read |
| dbg_reg_data | output | 32 | Value of the selected register |
| dbg_mem_sel | input | DAW | Data word index for the debug read |
| dbg_mem_data | output | 32 | Value of the selected data word |
| pc_o | output | 32 | Current program counter |

## Verification
The assertions assume that the instruction store has been filled before reset is released, so the fetched word is never undefined. They also assume that the preload port stays idle while the core runs, so the core is the only writer of the data store. The stimulus meets both assumptions. It loads the program and the operand words only while `rst_n` is low and drops `ld_en` before release. Every program keeps its data accesses inside the data store and ends in a jump to itself.

// File: rtl/sc_core_pkg.sv
// Shared encodings for the single-cycle core: ALU operation codes,
// ALU class codes, opcodes, function codes and the control bundle.
package sc_core_pkg;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_MEM   = 2'b00,
        CLS_CMP   = 2'b01,
        CLS_FUNCT = 2'b10,
        CLS_NONE  = 2'b11
    } alu_class_e;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef struct packed {
        logic       dst_rd;   // write rd (1) or rt (0)
        logic       src_imm;  // ALU B from extended immediate
        logic       wb_mem;   // write-back from data store
        logic       reg_wr;   // register write enable
        logic       mem_rd;   // data read in use
        logic       mem_wr;   // data write enable
        logic       branch;   // conditional branch
        logic       jump;     // unconditional jump
        alu_class_e cls;      // first-level ALU selection
    } ctrl_t;

endpackage

// File: rtl/sc_main_decode.sv
// First-level decoder: maps the opcode to datapath control points.
// Assumes nothing about the opcode; unknown values give a bundle with
// every enable low, so the instruction acts as a no-op.
module sc_main_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    // Opcode to control bundle.
    always_comb begin
        ctrl     = '0;
        ctrl.cls = CLS_NONE;
        case (opcode)
            OPC_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_wr = 1'b1;
                ctrl.cls    = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.src_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
                ctrl.reg_wr  = 1'b1;
                ctrl.mem_rd  = 1'b1;
                ctrl.cls     = CLS_MEM;
            end
            OPC_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
                ctrl.cls     = CLS_MEM;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.cls    = CLS_CMP;
            end
            OPC_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu_decode.sv
// Second-level decoder: ALU class plus funct field to ALU operation.
// op_ok drops for an unknown funct or for the "none" class; the top
// uses it to suppress the register write.
module sc_alu_decode
    import sc_core_pkg::*;
(
    input  alu_class_e cls,
    input  logic [5:0] funct,
    output alu_op_e    op,
    output logic       op_ok
);

    // Class/funct to ALU operation.
    always_comb begin
        op    = ALU_ADD;
        op_ok = 1'b1;
        case (cls)
            CLS_MEM: op = ALU_ADD;
            CLS_CMP: op = ALU_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  op = ALU_ADD;
                    FN_SUB:  op = ALU_SUB;
                    FN_AND:  op = ALU_AND;
                    FN_OR:   op = ALU_OR;
                    FN_SLT:  op = ALU_SLT;
                    default: op_ok = 1'b0;
                endcase
            end
            default: op_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
// Combinational ALU of width W with a zero flag valid for every op.
// Set-less-than compares as signed W-bit values.
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           zero
);

    // Operation select.
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end

    // Zero flag.
    always_comb zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
// Register file: NREGS x W, three combinational read ports, one write
// port on the rising edge. Entry 0 is hard zero. Synchronous active-low
// reset clears all entries.
module sc_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 32,
    localparam int RAW  = $clog2(NREGS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [W-1:0]   wdata,
    input  logic [RAW-1:0] ra_a,
    output logic [W-1:0]   rd_a,
    input  logic [RAW-1:0] ra_b,
    output logic [W-1:0]   rd_b,
    input  logic [RAW-1:0] ra_c,
    output logic [W-1:0]   rd_c
);

    logic [W-1:0] regs [NREGS];

    // Entry 0 is constant; the others are writable storage.
    always_comb regs[0] = '0;

    for (genvar g = 1; g < NREGS; g++) begin : g_reg
        // Reset or write one entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && waddr == RAW'(g))
                regs[g] <= wdata;
        end
    end

    // Read ports.
    always_comb begin
        rd_a = regs[ra_a];
        rd_b = regs[ra_b];
        rd_c = regs[ra_c];
    end

endmodule

// File: rtl/sc_word_mem.sv
// Word array with one write port on the rising edge and two
// combinational read ports. Contents are not reset.
module sc_word_mem #(
    parameter int W     = 32,
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_a,
    output logic [W-1:0]  rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_b
);

    logic [W-1:0] mem [WORDS];

    // Write port.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Read ports.
    always_comb begin
        rd_a = mem[ra_a];
        rd_b = mem[ra_b];
    end

endmodule

// File: rtl/sc_next_pc.sv
// Next-PC selection: sequential, taken-branch target or jump target.
// Reset forces zero. Assumes W >= 32 so the jump field fits.
module sc_next_pc #(
    parameter int W = 32
) (
    input  logic         rst_n,
    input  logic [W-1:0] pc,
    input  logic [15:0]  imm,
    input  logic [25:0]  jfield,
    input  logic         take_branch,
    input  logic         jump,
    output logic [W-1:0] pc_seq,
    output logic [W-1:0] pc_next
);

    logic [W-1:0] boff;

    // Sequential address and branch offset.
    always_comb begin
        pc_seq = pc + W'(4);
        boff   = {{(W-18){imm[15]}}, imm, 2'b00};
    end

    // Target select.
    always_comb begin
        if (!rst_n)
            pc_next = '0;
        else if (jump)
            pc_next = {pc_seq[W-1:28], jfield, 2'b00};
        else if (take_branch)
            pc_next = pc_seq + boff;
        else
            pc_next = pc_seq;
    end

endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: PC, decoders, register file, ALU and the two
// internal word stores. The host fills the stores through the preload
// port while reset is low and then releases reset. Assumes ld_en is low
// while the core runs.
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_en,
    input  logic           ld_dmem,
    input  logic [LAW-1:0] ld_addr,
    input  logic [31:0]    ld_data,
    input  logic [4:0]     dbg_reg_sel,
    output logic [31:0]    dbg_reg_data,
    input  logic [DAW-1:0] dbg_mem_sel,
    output logic [31:0]    dbg_mem_data,
    output logic [31:0]    pc_o
);

    localparam int W = 32;

    logic [W-1:0] pc_q, pc_seq, pc_next;
    logic [W-1:0] instr, unused_iport;
    ctrl_t        ctrl;
    alu_op_e      alu_op;
    logic         alu_ok;
    logic [W-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data, dmem_q;
    logic         alu_zero;
    logic         rf_we, core_mem_we;
    logic [4:0]   rf_waddr;
    logic         dm_we, im_we;
    logic [DAW-1:0] dm_waddr;
    logic [W-1:0]   dm_wdata;

    // Program counter register.
    always_ff @(posedge clk) begin
        pc_q <= pc_next;
    end

    // Instruction store: written only by preload.
    always_comb im_we = ld_en && !ld_dmem;

    sc_word_mem #(.W(W), .WORDS(IMEM_WORDS)) i_imem (
        .clk   (clk),
        .we    (im_we),
        .waddr (ld_addr[IAW-1:0]),
        .wdata (ld_data),
        .ra_a  (pc_q[IAW+1:2]),
        .rd_a  (instr),
        .ra_b  (pc_q[IAW+1:2]),
        .rd_b  (unused_iport)
    );

    sc_main_decode i_mdec (
        .opcode (instr[31:26]),
        .ctrl   (ctrl)
    );

    sc_alu_decode i_adec (
        .cls   (ctrl.cls),
        .funct (instr[5:0]),
        .op    (alu_op),
        .op_ok (alu_ok)
    );

    // Write-enable and destination selection.
    always_comb begin
        rf_waddr    = ctrl.dst_rd ? instr[15:11] : instr[20:16];
        rf_we       = rst_n && ctrl.reg_wr && alu_ok;
        core_mem_we = rst_n && ctrl.mem_wr;
        wb_data     = (ctrl.wb_mem && ctrl.mem_rd) ? dmem_q : alu_y;
    end

    sc_regfile #(.W(W), .NREGS(32)) i_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (wb_data),
        .ra_a  (instr[25:21]),
        .rd_a  (rs_val),
        .ra_b  (instr[20:16]),
        .rd_b  (rt_val),
        .ra_c  (dbg_reg_sel),
        .rd_c  (dbg_reg_data)
    );

    // Immediate extension and ALU operand B.
    always_comb begin
        imm_ext = {{(W-16){instr[15]}}, instr[15:0]};
        alu_b   = ctrl.src_imm ? imm_ext : rt_val;
    end

    sc_alu #(.W(W)) i_alu (
        .op   (alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data store port sharing: preload has priority over the core.
    always_comb begin
        dm_we    = (ld_en && ld_dmem) || core_mem_we;
        dm_waddr = ld_en ? ld_addr[DAW-1:0] : alu_y[DAW+1:2];
        dm_wdata = ld_en ? ld_data : rt_val;
    end

    sc_word_mem #(.W(W), .WORDS(DMEM_WORDS)) i_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .ra_a  (alu_y[DAW+1:2]),
        .rd_a  (dmem_q),
        .ra_b  (dbg_mem_sel),
        .rd_b  (dbg_mem_data)
    );

    sc_next_pc #(.W(W)) i_npc (
        .rst_n       (rst_n),
        .pc          (pc_q),
        .imm         (instr[15:0]),
        .jfield      (instr[25:0]),
        .take_branch (ctrl.branch && alu_zero),
        .jump        (ctrl.jump),
        .pc_seq      (pc_seq),
        .pc_next     (pc_next)
    );

    // PC output.
    always_comb pc_o = pc_q;

endmodule

// File: rtl/sc_core_checker.sv
// Temporal checks on the core, bound into sc_core. Assumes the
// instruction store is filled before reset release.
module sc_core_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        reg_we,
    input logic        mem_we
);

    logic [5:0]  opc;
    logic [31:0] seq, jtgt, btgt;
    logic        known;

    // Reference targets from the instruction fields.
    always_comb begin
        opc   = instr[31:26];
        seq   = pc + 32'd4;
        jtgt  = {seq[31:28], instr[25:0], 2'b00};
        btgt  = seq + {{14{instr[15]}}, instr[15:0], 2'b00};
        known = (opc == 6'b000000) || (opc == 6'b100011) || (opc == 6'b101011)
             || (opc == 6'b000100) || (opc == 6'b000010);
    end

    p_pc_zero_at_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pc == 32'd0);

    p_pc_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);

    p_pc_sequential_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != 6'b000100 && opc != 6'b000010) |=> pc == $past(seq));

    p_jump_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 6'b000010) |=> pc == $past(jtgt));

    p_branch_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 6'b000100 && rs_val == rt_val) |=> pc == $past(btgt));

    p_branch_fallthrough_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 6'b000100 && rs_val != rt_val) |=> pc == $past(seq));

    p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> (!reg_we && !mem_we));

    p_store_no_regwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !reg_we);

endmodule

bind sc_core sc_core_checker i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc     (pc_q),
    .instr  (instr),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .reg_we (rf_we),
    .mem_we (core_mem_we)
);

// File: tb/test_sc_core.sv
// Runs one fixed program over a sweep of operand pairs and checks the
// stored results, the branch, r0, a negative offset, the no-op cases
// and the final jump address.
module test_sc_core;

    localparam int LAW = 6;
    localparam int DAW = 6;
    localparam int NPAIRS = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ld_en = 1'b0;
    logic           ld_dmem = 1'b0;
    logic [LAW-1:0] ld_addr = '0;
    logic [31:0]    ld_data = '0;
    logic [4:0]     dbg_reg_sel = '0;
    logic [31:0]    dbg_reg_data;
    logic [DAW-1:0] dbg_mem_sel = '0;
    logic [31:0]    dbg_mem_data;
    logic [31:0]    pc_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sc_core i_sc_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_en        (ld_en),
        .ld_dmem      (ld_dmem),
        .ld_addr      (ld_addr),
        .ld_data      (ld_data),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_data (dbg_reg_data),
        .dbg_mem_sel  (dbg_mem_sel),
        .dbg_mem_data (dbg_mem_data),
        .pc_o         (pc_o)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] prog(int i);
        case (i)
            0:  return enc_i(6'b100011, 0, 1, 16'd0);       // load r1 <- w0
            1:  return enc_i(6'b100011, 0, 2, 16'd4);       // load r2 <- w1
            2:  return enc_r(1, 2, 3, 6'b100000);           // add
            3:  return enc_r(1, 2, 4, 6'b100010);           // sub
            4:  return enc_r(1, 2, 5, 6'b100100);           // and
            5:  return enc_r(1, 2, 6, 6'b100101);           // or
            6:  return enc_r(1, 2, 7, 6'b101010);           // slt
            7:  return enc_i(6'b101011, 0, 3, 16'd8);
            8:  return enc_i(6'b101011, 0, 4, 16'd12);
            9:  return enc_i(6'b101011, 0, 5, 16'd16);
            10: return enc_i(6'b101011, 0, 6, 16'd20);
            11: return enc_i(6'b101011, 0, 7, 16'd24);
            12: return enc_i(6'b000100, 1, 2, 16'd1);       // beq skip next
            13: return enc_i(6'b101011, 0, 1, 16'd28);      // w7 <- r1 if not taken
            14: return enc_r(1, 2, 0, 6'b100000);           // write r0 (dropped)
            15: return enc_i(6'b101011, 0, 0, 16'd32);      // w8 <- r0
            16: return enc_i(6'b100011, 0, 10, 16'd40);     // r10 <- w10 (=44)
            17: return enc_i(6'b100011, 10, 11, 16'hFFFC);  // r11 <- mem[44-4]
            18: return enc_i(6'b101011, 0, 11, 16'd48);     // w12 <- r11
            19: return enc_r(1, 2, 1, 6'b000111);           // unknown funct
            20: return enc_i(6'b111111, 0, 1, 16'd4);       // unknown opcode
            21: return enc_i(6'b101011, 0, 1, 16'd52);      // w13 <- r1
            22: return {6'b000010, 26'd22};                 // jump to self
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [63:0] pair(int k);
        case (k)
            0:  return {32'd0, 32'd0};
            1:  return {32'd1, 32'd2};
            2:  return {32'd5, 32'd5};
            3:  return {32'hFFFFFFFF, 32'd1};
            4:  return {32'h7FFFFFFF, 32'h80000000};
            5:  return {32'h80000000, 32'd1};
            6:  return {32'hFFFF0000, 32'h00FFFF00};
            7:  return {32'd123456, 32'd123456};
            8:  return {32'hFFFFFFFB, 32'hFFFFFFF9};
            9:  return {32'hA5A5A5A5, 32'h5A5A5A5A};
            10: return {32'd100, 32'hFFFFFF9C};
            default: return {32'h12345678, 32'd0};
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_word(bit to_dmem, int addr, logic [31:0] data);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_dmem = to_dmem;
        ld_addr = LAW'(addr);
        ld_data = data;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    task automatic read_mem(int idx, output logic [31:0] v);
        dbg_mem_sel = DAW'(idx);
        #1 v = dbg_mem_data;
    endtask

    initial begin
        logic [31:0] v, a, b, slt;
        for (int k = 0; k < NPAIRS; k++) begin
            {a, b} = pair(k);
            @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            if (k == 0) begin
                check("R1 pc in reset", pc_o, 32'd0);
                dbg_reg_sel = 5'd5;
                #1 check("R1 reg cleared", dbg_reg_data, 32'd0);
            end
            for (int i = 0; i < 23; i++) load_word(1'b0, i, prog(i));
            load_word(1'b1, 0, a);
            load_word(1'b1, 1, b);
            load_word(1'b1, 7, 32'hDEADBEEF);
            load_word(1'b1, 8, 32'h5A5A5A5A);
            load_word(1'b1, 10, 32'd44);
            load_word(1'b1, 12, 32'd0);
            load_word(1'b1, 13, 32'd0);
            if (k == 0) begin
                read_mem(10, v);
                check("R2 preload data word", v, 32'd44);
            end
            @(negedge clk);
            rst_n = 1'b1;
            repeat (30) @(negedge clk);
            slt = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            read_mem(2, v);  check("R3 add", v, a + b);
            read_mem(3, v);  check("R3 sub", v, a - b);
            read_mem(4, v);  check("R3 and", v, a & b);
            read_mem(5, v);  check("R3 or", v, a | b);
            read_mem(6, v);  check("R4 slt signed", v, slt);
            read_mem(7, v);  check("R6 branch", v, (a == b) ? 32'hDEADBEEF : a);
            read_mem(8, v);  check("R8 r0 stays zero", v, 32'd0);
            read_mem(12, v); check("R5 negative offset load/store", v, 32'd44);
            read_mem(13, v); check("R9 no-op keeps r1", v, a);
            dbg_reg_sel = 5'd0;
            #1 check("R8 r0 read", dbg_reg_data, 32'd0);
            check("R7 jump target", pc_o, 32'd88);
            check("R10 run ends at jump", pc_o[1:0] == 2'b00 ? 32'd1 : 32'd0, 32'd1);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule